// File: doc/BRIEF.md
# Wake and kickstart interrupt flags

This block is the status and control register pair of a real-time clock. It records three events in sticky flags: a wake-up alarm match, a press of the kickstart button, and a RAM-clear request. From those flags and their enable bits it drives two active-low outputs. The first is an interrupt request to the host. The second is a power-on request to the system power supply. Software reads and writes both registers through a synchronous port. It acknowledges an event by writing 0 to its flag, and it can raise an event on purpose by writing 1.

The outputs depend on whether main supply is present, which the `vcc_ok` input reports. While supply is absent, an enabled wake or kickstart flag asserts only the power-on request. The interrupt follows once supply returns. While supply is present, both outputs assert together. A power-fail select bit chooses between two behaviours for the power-on output during a supply loss. With the bit at 0 the output floats, and with the bit at 1 it stays actively driven. An output-enable signal models this choice.

The kickstart and clear inputs come from outside the clock domain, so each passes through a synchronizer before its falling edge is detected. The wake pulse is already synchronous to `clk`.

Top module: `rtc_evt_flags`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `irq_n` and `pwr_n` are 1 and `pwr_oe` is 1. The flag register reads 0x00 and the control register reads 0x20.
- R2: A high cycle on `wake_evt` sets the wake flag (flag register bit 0). The flag stays set when the pulse ends, and only a write of 0 to that bit clears it. If a hardware event and a write of 0 hit the same flag in the same cycle, the event wins.
- R3: A write of 1 to a flag bit sets that flag and produces the same output response as the hardware event would.
- R4: A low pulse on `kick_n` sets the kickstart flag (flag register bit 1). The flag is set on the falling edge after synchronization.
- R5: A high-to-low transition on `clr_n` sets the RAM-clear flag (flag register bit 2) only while the clear-enable bit (control bit 2) is 1. With that bit at 0 the transition is ignored.
- R6: With the RAM-clear interrupt enable (control bit 3) at 1 and `vcc_ok` high, a set RAM-clear flag drives `irq_n` low. The RAM-clear flag never drives `pwr_n`.
- R7: While `vcc_ok` is 0, a wake flag with its enable (control bit 0) or a kickstart flag with its enable (control bit 1) drives `pwr_n` low, and `irq_n` stays 1. When `vcc_ok` returns to 1, `irq_n` goes low.
- R8: While `vcc_ok` is 1, a wake or kickstart flag with its enable set drives both `irq_n` and `pwr_n` low.
- R9: A wake or kickstart flag whose enable bit is 0 has no effect on `irq_n` or `pwr_n`.
- R10: `pwr_oe` is 1 while `vcc_ok` is 1. While `vcc_ok` is 0, `pwr_oe` equals the power-fail select bit (control bit 4), one cycle after either input changes.
- R11: A rising edge of `vcc_ok` sets the 32 kHz output enable (control bit 5). This takes priority over a software write in the same cycle.
- R12: `irq_n` and `pwr_n` are level outputs. They return to 1 only after every flag that contributes through its enable has been cleared.
- R13: Flag register bits 7:3 and control register bits 7:6 hold whatever is written to them, read back unchanged, and have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 flag register, 1 control register |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read target: 0 flag register, 1 control register |
| rd_data | output | 8 | Registered read data, valid one cycle after `rd_sel` |
| wake_evt | input | 1 | Synchronous single-cycle pulse from the alarm comparator |
| kick_n | input | 1 | Asynchronous active-low kickstart button |
| clr_n | input | 1 | Asynchronous active-low RAM-clear request |
| vcc_ok | input | 1 | Main supply present |
| irq_n | output | 1 | Active-low interrupt request (registered) |
| pwr_n | output | 1 | Active-low system power-on request (registered) |
| pwr_oe | output | 1 | Output enable for `pwr_n`; 0 means high impedance |

## Verification
A flag stuck at 0, or one that fails to stay set, shows up on `irq_n` and `pwr_n` one cycle after the flag register should have changed. It also shows up on the next read-back of that register. A wrong gating of the interrupt by `vcc_ok` appears as `irq_n` falling while supply is absent, or not falling on the cycle after supply returns. An edge detector or synchronizer that is broken shows as a flag that never sets within the few cycles that the synchronizer stages account for.

// File: rtl/rtc_evt_pkg.sv
package rtc_evt_pkg;
  localparam int REG_W = 8;

  // flag register bit positions (wake and kick share index with their enables)
  localparam int F_WAKE = 0;
  localparam int F_KICK = 1;
  localparam int F_CLR  = 2;

  // control register bit positions
  localparam int C_WIE   = 0;
  localparam int C_KIE   = 1;
  localparam int C_CLREN = 2;
  localparam int C_CIE   = 3;
  localparam int C_PFK   = 4;
  localparam int C_OSC   = 5;

  localparam logic [REG_W-1:0] CTRL_RST = 8'h20;

  typedef enum logic {
    SEL_FLAGS = 1'b0,
    SEL_CTRL  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/rtc_edge_sync.sv
module rtc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic fall
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], din};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign fall = prev_q & ~sh_q[STAGES-1];
endmodule

// File: rtl/rtc_evt_regs.sv
module rtc_evt_regs
  import rtc_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             wake_set,
  input  logic             kick_fall,
  input  logic             clr_fall,
  input  logic             vcc_ok,
  output logic [REG_W-1:0] flags_q,
  output logic [REG_W-1:0] ctrl_q
);
  logic [REG_W-1:0] flags_d, ctrl_d;
  logic             vcc_q;
  logic             pwr_up;

  assign pwr_up = vcc_ok & ~vcc_q;

  always_comb begin
    flags_d = flags_q;
    if (wr_en && wr_sel == SEL_FLAGS) flags_d = wr_data;
    // hardware events dominate a same-cycle software clear
    if (wake_set)                      flags_d[F_WAKE] = 1'b1;
    if (kick_fall)                     flags_d[F_KICK] = 1'b1;
    if (clr_fall && ctrl_q[C_CLREN])   flags_d[F_CLR]  = 1'b1;
  end

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en && wr_sel == SEL_CTRL) ctrl_d = wr_data;
    if (pwr_up)                      ctrl_d[C_OSC] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      ctrl_q  <= CTRL_RST;
      vcc_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      ctrl_q  <= ctrl_d;
      vcc_q   <= vcc_ok;
    end
  end
endmodule

// File: rtl/rtc_evt_outs.sv
module rtc_evt_outs
  import rtc_evt_pkg::*;
#(
  parameter int N_WAKE_SRC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] flags_q,
  input  logic [REG_W-1:0] ctrl_q,
  input  logic             vcc_ok,
  output logic             irq_n,
  output logic             pwr_n,
  output logic             pwr_oe
);
  logic [N_WAKE_SRC-1:0] src;
  logic                  wake_req, clr_req, irq_req;

  // wake-type sources: flag i is gated by control bit i
  for (genvar i = 0; i < N_WAKE_SRC; i++) begin : g_src
    assign src[i] = flags_q[i] & ctrl_q[i];
  end

  assign wake_req = |src;
  assign clr_req  = flags_q[F_CLR] & ctrl_q[C_CIE];
  assign irq_req  = vcc_ok & (wake_req | clr_req);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_n  <= 1'b1;
      pwr_n  <= 1'b1;
      pwr_oe <= 1'b1;
    end else begin
      irq_n  <= ~irq_req;
      pwr_n  <= ~wake_req;
      pwr_oe <= vcc_ok | ctrl_q[C_PFK];
    end
  end
endmodule

// File: rtl/rtc_evt_flags.sv
module rtc_evt_flags
  import rtc_evt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_sel,
  output logic [REG_W-1:0] rd_data,
  input  logic             wake_evt,
  input  logic             kick_n,
  input  logic             clr_n,
  input  logic             vcc_ok,
  output logic             irq_n,
  output logic             pwr_n,
  output logic             pwr_oe
);
  logic [REG_W-1:0] flags_q, ctrl_q;
  logic             kick_fall, clr_fall;

  rtc_edge_sync #(.STAGES(SYNC_STAGES)) u_kick_sync (
    .clk(clk), .rst(rst), .din(kick_n), .fall(kick_fall)
  );

  rtc_edge_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
    .clk(clk), .rst(rst), .din(clr_n), .fall(clr_fall)
  );

  rtc_evt_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .wake_set(wake_evt), .kick_fall(kick_fall), .clr_fall(clr_fall),
    .vcc_ok(vcc_ok), .flags_q(flags_q), .ctrl_q(ctrl_q)
  );

  rtc_evt_outs #(.N_WAKE_SRC(2)) u_outs (
    .clk(clk), .rst(rst), .flags_q(flags_q), .ctrl_q(ctrl_q),
    .vcc_ok(vcc_ok), .irq_n(irq_n), .pwr_n(pwr_n), .pwr_oe(pwr_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= (rd_sel == SEL_CTRL) ? ctrl_q : flags_q;
  end
endmodule

// File: rtl/rtc_evt_flags_chk.sv
module rtc_evt_flags_chk
  import rtc_evt_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             wr_sel,
  input logic             wake_evt,
  input logic             vcc_ok,
  input logic             irq_n,
  input logic             pwr_n,
  input logic             pwr_oe,
  input logic [REG_W-1:0] flags_q,
  input logic [REG_W-1:0] ctrl_q
);
  a_r2_wake_sets: assert property (@(posedge clk) disable iff (rst)
    wake_evt |=> flags_q[F_WAKE]);

  a_r5_clr_gated: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[C_CLREN] && !flags_q[F_CLR] && !(wr_en && wr_sel == SEL_FLAGS))
      |=> !flags_q[F_CLR]);

  a_r7_no_irq_without_vcc: assert property (@(posedge clk) disable iff (rst)
    !vcc_ok |=> irq_n);

  a_r8_wake_drives_pwr: assert property (@(posedge clk) disable iff (rst)
    ((flags_q[F_WAKE] && ctrl_q[C_WIE]) || (flags_q[F_KICK] && ctrl_q[C_KIE]))
      |=> !pwr_n);

  a_r9_pwr_needs_source: assert property (@(posedge clk) disable iff (rst)
    !((flags_q[F_WAKE] && ctrl_q[C_WIE]) || (flags_q[F_KICK] && ctrl_q[C_KIE]))
      |=> pwr_n);

  a_r10_oe_with_vcc: assert property (@(posedge clk) disable iff (rst)
    vcc_ok |=> pwr_oe);

  a_r11_osc_on_powerup: assert property (@(posedge clk) disable iff (rst)
    $rose(vcc_ok) |=> ctrl_q[C_OSC]);
endmodule

bind rtc_evt_flags rtc_evt_flags_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wake_evt(wake_evt),
  .vcc_ok(vcc_ok), .irq_n(irq_n), .pwr_n(pwr_n), .pwr_oe(pwr_oe),
  .flags_q(flags_q), .ctrl_q(ctrl_q)
);

// File: tb/rtc_evt_flags_tb.sv
module rtc_evt_flags_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_sel = 1'b0;
  logic [7:0] rd_data;
  logic       wake_evt = 1'b0;
  logic       kick_n = 1'b1;
  logic       clr_n = 1'b1;
  logic       vcc_ok = 1'b1;
  logic       irq_n, pwr_n, pwr_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_evt_flags dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .wake_evt(wake_evt), .kick_n(kick_n),
    .clr_n(clr_n), .vcc_ok(vcc_ok), .irq_n(irq_n), .pwr_n(pwr_n), .pwr_oe(pwr_oe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    @(negedge clk);
    rd_sel = sel;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic outs(input string tag, input logic ei, input logic ep);
    chk({tag, " irq_n"}, {7'd0, irq_n}, {7'd0, ei});
    chk({tag, " pwr_n"}, {7'd0, pwr_n}, {7'd0, ep});
  endtask

  task automatic t_reset();
    logic [7:0] d;
    @(negedge clk);
    outs("R1", 1'b1, 1'b1);
    chk("R1 pwr_oe", {7'd0, pwr_oe}, 8'h01);
    rd(1'b0, d); chk("R1 flags", d, 8'h00);
    rd(1'b1, d); chk("R1 ctrl", d, 8'h20);
  endtask

  task automatic t_wake_vcc_on();
    logic [7:0] d;
    wr(1'b1, 8'h21);
    @(negedge clk); wake_evt = 1'b1;
    @(negedge clk); wake_evt = 1'b0;
    settle();
    outs("R8 wake", 1'b0, 1'b0);
    rd(1'b0, d); chk("R2 wake flag sticky", d, 8'h01);
    wr(1'b0, 8'h00); settle();
    outs("R12 wake cleared", 1'b1, 1'b1);
  endtask

  task automatic t_wake_disabled();
    logic [7:0] d;
    wr(1'b1, 8'h20);
    @(negedge clk); wake_evt = 1'b1;
    @(negedge clk); wake_evt = 1'b0;
    settle();
    outs("R9 wake disabled", 1'b1, 1'b1);
    rd(1'b0, d); chk("R2 flag set while disabled", d, 8'h01);
    wr(1'b0, 8'h00);
  endtask

  task automatic t_kick_vcc_off();
    logic [7:0] d;
    wr(1'b1, 8'h22);
    @(negedge clk); vcc_ok = 1'b0;
    wr(1'b1, 8'h02);                  // clear osc enable while supply is off
    @(negedge clk); kick_n = 1'b0;
    repeat (3) @(negedge clk); kick_n = 1'b1;
    settle();
    outs("R7 supply off", 1'b1, 1'b0);
    rd(1'b0, d); chk("R4 kick flag", d, 8'h02);
    vcc_ok = 1'b1;
    settle();
    outs("R7 supply back", 1'b0, 1'b0);
    rd(1'b1, d); chk("R11 osc forced", d, 8'h22);
    wr(1'b0, 8'h00); settle();
    outs("R12 kick cleared", 1'b1, 1'b1);
  endtask

  task automatic t_two_sources();
    wr(1'b1, 8'h23);
    wr(1'b0, 8'h03); settle();
    outs("R3 forced both", 1'b0, 1'b0);
    wr(1'b0, 8'h02); settle();
    outs("R12 one source left", 1'b0, 1'b0);
    wr(1'b0, 8'h00); settle();
    outs("R12 none left", 1'b1, 1'b1);
  endtask

  task automatic t_clear();
    logic [7:0] d;
    wr(1'b1, 8'h28);                  // interrupt enabled, clear disabled
    @(negedge clk); clr_n = 1'b0;
    repeat (3) @(negedge clk); clr_n = 1'b1;
    settle();
    rd(1'b0, d); chk("R5 clear ignored", d, 8'h00);
    outs("R5 outputs idle", 1'b1, 1'b1);
    wr(1'b1, 8'h2C);
    @(negedge clk); clr_n = 1'b0;
    repeat (3) @(negedge clk); clr_n = 1'b1;
    settle();
    rd(1'b0, d); chk("R5 clear flag", d, 8'h04);
    outs("R6 clear irq", 1'b0, 1'b1);
    wr(1'b0, 8'h00); settle();
    outs("R12 clear acked", 1'b1, 1'b1);
  endtask

  task automatic t_pwr_oe();
    wr(1'b1, 8'h20);
    @(negedge clk); vcc_ok = 1'b0;
    settle();
    chk("R10 oe float", {7'd0, pwr_oe}, 8'h00);
    wr(1'b1, 8'h10); settle();
    chk("R10 oe kept", {7'd0, pwr_oe}, 8'h01);
    vcc_ok = 1'b1; settle();
    wr(1'b1, 8'h20); settle();
    chk("R10 oe supply", {7'd0, pwr_oe}, 8'h01);
  endtask

  task automatic t_force_and_reserved();
    logic [7:0] d;
    wr(1'b1, 8'h22);
    wr(1'b0, 8'h02); settle();
    outs("R3 forced kick", 1'b0, 1'b0);
    wr(1'b0, 8'hF8); settle();
    rd(1'b0, d); chk("R13 flag reserved", d, 8'hF8);
    outs("R13 flag reserved no effect", 1'b1, 1'b1);
    wr(1'b1, 8'hE0); settle();
    rd(1'b1, d); chk("R13 ctrl reserved", d, 8'hE0);
    outs("R13 ctrl reserved no effect", 1'b1, 1'b1);
    wr(1'b0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_wake_vcc_on();
    t_wake_disabled();
    t_kick_vcc_off();
    t_two_sources();
    t_clear();
    t_pwr_oe();
    t_force_and_reserved();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule